// File: doc/BRIEF.md
# PLL Clock-Source Sequencer

This block decides where the system clock comes from. Out of reset the system clock is the raw oscillator. Software can then hand the system clock over to the PLL, one write at a time. It first sets the enable bit. It then waits until the lock flag reads back as one. Only then does it set the connect bit. The lock flag is the AND of two conditions: the lock indication from the PLL model, brought in through two flops, and a settle counter that covers the PLL's 100 µs start-up time, counted in oscillator cycles.

The PLL side of the clock comes from a power-of-two post-divider, which runs on the fast VCO-rate clock. A two-bit code selects a ratio of 2, 4, 8 or 16, so every output has an even duty cycle. A change of the code takes effect only while the system clock is on the oscillator. The source switch uses a two-flop handshake on each side. One clock is switched off, in its own domain, before the other is switched on, so neither clock can produce a cut-short pulse.

Top module: `pll_clk_seq`

## Requirements
- R1: After reset, the enable, lock and connect status are 0, the active divider code is 0, and the system clock is the oscillator.
- R2: The lock status rises only on the edge after all of these hold: enable is set, the settle counter has counted SETTLE_CYCLES oscillator edges since the enable was captured, and the two-flop-synchronised lock input is high.
- R3: A write to control bit 1 (connect) takes effect only if the lock status was already 1 before that write. Otherwise the connect status stays 0 and the clock stays on the oscillator.
- R4: While connected, the system clock is the post-divided VCO clock, with its high time equal to half its period.
- R5: The divider code in control bits [3:2] selects the ratio. Code 0 gives 2, 1 gives 4, 2 gives 8 and 3 gives 16.
- R6: A write with control bit 0 (enable) at 0 clears enable, lock and connect on that edge. The clock then returns to the oscillator.
- R7: A divider code written while connected is held and does not change the active code. It is applied once the clock is back on the oscillator.
- R8: At no time are both sources gated onto the system clock, and no high or low phase of the system clock is shorter than the faster source's half period.
- R9: If the lock input falls while enabled, the lock and connect status clear three oscillator edges later, and the clock returns to the oscillator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk_i | input | 1 | Oscillator clock; also clocks the control registers |
| vco_clk_i | input | 1 | Fast VCO-rate clock fed to the post-divider |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Control write strobe, one oscillator cycle |
| wr_data_i | input | 4 | Control word: bit0 enable, bit1 connect, bits[3:2] divider code |
| pll_lock_i | input | 1 | Lock indication from the PLL model (asynchronous) |
| sys_clk_o | output | 1 | Selected system clock |
| en_o | output | 1 | Enable status |
| lock_o | output | 1 | Lock status |
| conn_o | output | 1 | Connect status (PLL requested as source) |
| div_o | output | 2 | Active divider code |
| osc_on_o | output | 1 | Oscillator gated onto the output |
| pll_on_o | output | 1 | PLL gated onto the output |

## Verification
The main function is driven through three kinds of step. Connect attempts are made before enable, during the settle window, and after lock; these separate an early-accept bug from a correct refusal. Each divider code is applied by the bypass, write and connect sequence, and the output period and high time are measured; this catches a wrong tap or a lost duty cycle. Other cases end a connected session: by a divider write while connected, by disable, and by loss of the lock input. These show apart the holding of a change, forced bypass, and lock-loss recovery. Throughout the run, a phase-width monitor on the output clock catches any runt pulse at a switch.

// File: rtl/pll_clk_seq_pkg.sv
package pll_clk_seq_pkg;

    // Control word layout
    localparam int CTRL_W   = 4;
    localparam int BIT_EN   = 0;
    localparam int BIT_CONN = 1;
    localparam int DIV_LSB  = 2;

    // Post-divider: one tap per ratio 2,4,8,16
    localparam int DIV_TAPS  = 4;
    localparam int DIV_SEL_W = $clog2(DIV_TAPS);
    localparam int DIV_MSB   = DIV_LSB + DIV_SEL_W - 1;

    typedef enum logic [DIV_SEL_W-1:0] {
        RATIO_2  = 2'd0,
        RATIO_4  = 2'd1,
        RATIO_8  = 2'd2,
        RATIO_16 = 2'd3
    } ratio_code_e;

endpackage

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
    import pll_clk_seq_pkg::*;
#(
    parameter int SETTLE_CYCLES = 1200
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 wr_i,
    input  logic [CTRL_W-1:0]    wr_data_i,
    input  logic                 lock_raw_i,
    input  logic                 osc_on_i,
    output logic                 en_o,
    output logic                 lock_o,
    output logic                 conn_o,
    output logic [DIV_SEL_W-1:0] div_o
);

    localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SETTLE_CYCLES);

    typedef struct packed {
        logic                 en;
        logic                 lock;
        logic                 conn;
        logic [DIV_SEL_W-1:0] pend;
        logic [DIV_SEL_W-1:0] div;
        logic [CNT_W-1:0]     cnt;
        logic [1:0]           sync;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic     en_nx;

    always_comb begin
        st_d  = st_q;
        en_nx = wr_i ? wr_data_i[BIT_EN] : st_q.en;
        st_d.en   = en_nx;
        // two-flop capture of the asynchronous lock indication
        st_d.sync = {st_q.sync[0], lock_raw_i};
        // settle counter restarts whenever the PLL is disabled
        if (!en_nx) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        st_d.lock = en_nx && (st_q.cnt == CNT_MAX) && st_q.sync[1];
        // connect is accepted only from a locked state and dies with lock
        st_d.conn = st_d.lock &&
                    (wr_i ? (wr_data_i[BIT_CONN] && st_q.lock) : st_q.conn);
        if (wr_i) begin
            st_d.pend = wr_data_i[DIV_MSB:DIV_LSB];
        end
        // divider code moves only while fully back on the oscillator
        if (!st_q.conn && osc_on_i) begin
            st_d.div = st_q.pend;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o   = st_q.en;
    assign lock_o = st_q.lock;
    assign conn_o = st_q.conn;
    assign div_o  = st_q.div;

    // R2: lock status only with the counter expired and enable set
    a_r2_lock_settled: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.lock |-> (st_q.en && st_q.cnt == CNT_MAX));

    // R3: connect never rises without a prior lock
    a_r3_conn_after_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.conn) |-> $past(st_q.lock));

    // R6: a disabling write clears lock and connect on the next edge
    a_r6_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && !wr_data_i[BIT_EN]) |=> (!st_q.lock && !st_q.conn && !st_q.en));

    // R7: active code frozen while connected
    a_r7_div_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(st_q.conn) |-> $stable(st_q.div));

    // R9: a low synchronised lock input forces lock low
    a_r9_lock_loss: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_q.sync[1] |=> !st_q.lock);

endmodule

// File: rtl/pll_post_div.sv
module pll_post_div
    import pll_clk_seq_pkg::*;
#(
    parameter int N_TAPS = DIV_TAPS
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic [$clog2(N_TAPS)-1:0]    sel_i,
    output logic                         clk_o
);

    logic [N_TAPS-1:0] cnt_d, cnt_q;
    logic [N_TAPS-1:0] tap;

    always_comb begin
        cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // bit g of a free-running counter toggles every 2^g input cycles,
    // giving ratio 2^(g+1) with an even duty cycle
    for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
        assign tap[g] = cnt_q[g];
    end

    assign clk_o = tap[sel_i];

endmodule

// File: rtl/pll_clk_switch.sv
module pll_clk_switch (
    input  logic osc_clk_i,
    input  logic pll_clk_i,
    input  logic rst_ni,
    input  logic sel_pll_i,
    output logic clk_o,
    output logic osc_on_o,
    output logic pll_on_o
);

    logic osc_s1_d, osc_s1_q, osc_s2_q;
    logic pll_s1_d, pll_s1_q, pll_s2_q;

    always_comb begin
        osc_s1_d = !sel_pll_i && !pll_s2_q;
        pll_s1_d =  sel_pll_i && !osc_s2_q;
    end

    // oscillator side: capture on rise, gate on fall
    always_ff @(posedge osc_clk_i or negedge rst_ni) begin
        if (!rst_ni) osc_s1_q <= 1'b1;
        else         osc_s1_q <= osc_s1_d;
    end
    always_ff @(negedge osc_clk_i or negedge rst_ni) begin
        if (!rst_ni) osc_s2_q <= 1'b1;
        else         osc_s2_q <= osc_s1_q;
    end

    // PLL side: same structure in the divided-clock domain
    always_ff @(posedge pll_clk_i or negedge rst_ni) begin
        if (!rst_ni) pll_s1_q <= 1'b0;
        else         pll_s1_q <= pll_s1_d;
    end
    always_ff @(negedge pll_clk_i or negedge rst_ni) begin
        if (!rst_ni) pll_s2_q <= 1'b0;
        else         pll_s2_q <= pll_s1_q;
    end

    assign clk_o    = (osc_clk_i & osc_s2_q) | (pll_clk_i & pll_s2_q);
    assign osc_on_o = osc_s2_q;
    assign pll_on_o = pll_s2_q;

    // R8: the two gates are never open together
    a_r8_one_source: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
        !(osc_s2_q && pll_s2_q));

endmodule

// File: rtl/pll_clk_seq.sv
module pll_clk_seq
    import pll_clk_seq_pkg::*;
#(
    parameter int SETTLE_CYCLES = 1200
) (
    input  logic                 osc_clk_i,
    input  logic                 vco_clk_i,
    input  logic                 rst_ni,
    input  logic                 wr_i,
    input  logic [CTRL_W-1:0]    wr_data_i,
    input  logic                 pll_lock_i,
    output logic                 sys_clk_o,
    output logic                 en_o,
    output logic                 lock_o,
    output logic                 conn_o,
    output logic [DIV_SEL_W-1:0] div_o,
    output logic                 osc_on_o,
    output logic                 pll_on_o
);

    logic pll_div_clk;
    logic osc_on;

    pll_seq_ctrl #(
        .SETTLE_CYCLES(SETTLE_CYCLES)
    ) u_ctrl (
        .clk_i      (osc_clk_i),
        .rst_ni     (rst_ni),
        .wr_i       (wr_i),
        .wr_data_i  (wr_data_i),
        .lock_raw_i (pll_lock_i),
        .osc_on_i   (osc_on),
        .en_o       (en_o),
        .lock_o     (lock_o),
        .conn_o     (conn_o),
        .div_o      (div_o)
    );

    // div_o crosses into the VCO domain; it only moves while the PLL
    // gate is shut, so a transient tap choice never reaches sys_clk_o
    pll_post_div #(
        .N_TAPS(DIV_TAPS)
    ) u_div (
        .clk_i  (vco_clk_i),
        .rst_ni (rst_ni),
        .sel_i  (div_o),
        .clk_o  (pll_div_clk)
    );

    pll_clk_switch u_sw (
        .osc_clk_i (osc_clk_i),
        .pll_clk_i (pll_div_clk),
        .rst_ni    (rst_ni),
        .sel_pll_i (conn_o),
        .clk_o     (sys_clk_o),
        .osc_on_o  (osc_on),
        .pll_on_o  (pll_on_o)
    );

    assign osc_on_o = osc_on;

endmodule

// File: tb/sim_pll_clk_seq.sv
`timescale 1ns/1ps
module sim_pll_clk_seq;

    localparam int  S        = 1200;
    localparam real OSC_P    = 4.0;
    localparam real VCO_P    = 1.25;

    logic       osc_clk = 1'b0;
    logic       vco_clk = 1'b0;
    logic       rst_n   = 1'b0;
    logic       wr      = 1'b0;
    logic [3:0] wd      = 4'd0;
    logic       lock_in = 1'b0;
    logic       sys_clk, en_o, lock_o, conn_o, osc_on, pll_on;
    logic [1:0] div_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #(OSC_P/2) osc_clk = ~osc_clk;
    always #(VCO_P/2) vco_clk = ~vco_clk;

    pll_clk_seq #(.SETTLE_CYCLES(S)) u0 (
        .osc_clk_i (osc_clk), .vco_clk_i (vco_clk), .rst_ni (rst_n),
        .wr_i (wr), .wr_data_i (wd), .pll_lock_i (lock_in),
        .sys_clk_o (sys_clk), .en_o (en_o), .lock_o (lock_o),
        .conn_o (conn_o), .div_o (div_o), .osc_on_o (osc_on),
        .pll_on_o (pll_on)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_r(input bit ok, input string req, input string what,
                         input real act, input real exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0.3f expected %0.3f", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit       m_en, m_lock, m_conn, m_s1, m_s2;
    bit [1:0] m_pend, m_div;
    int       m_cnt, byp_age;
    bit       model_go = 1'b0;

    always @(posedge osc_clk) begin
        bit en_nx, lock_nx, conn_nx;
        if (!rst_n) begin
            m_en = 0; m_lock = 0; m_conn = 0; m_s1 = 0; m_s2 = 0;
            m_pend = 0; m_div = 0; m_cnt = 0; byp_age = 0;
        end else begin
            en_nx   = wr ? wd[0] : m_en;
            lock_nx = en_nx && (m_cnt == S) && m_s2;
            conn_nx = lock_nx && (wr ? (wd[1] && m_lock) : m_conn);
            if (!m_conn && byp_age >= 24) m_div = m_pend;
            if (wr) m_pend = wd[3:2];
            if (!en_nx)         m_cnt = 0;
            else if (m_cnt < S) m_cnt = m_cnt + 1;
            m_s2 = m_s1; m_s1 = lock_in;
            m_en = en_nx; m_lock = lock_nx; m_conn = conn_nx;
            if (m_conn)            byp_age = 0;
            else if (byp_age < 1000) byp_age = byp_age + 1;
        end
    end

    always @(negedge osc_clk) begin
        if (model_go && rst_n) begin
            chk(en_o == m_en,     "R6", "enable status",  en_o,   m_en);
            chk(lock_o == m_lock, "R2", "lock status",    lock_o, m_lock);
            chk(conn_o == m_conn, "R3", "connect status", conn_o, m_conn);
            if (m_conn || byp_age >= 28)
                chk(div_o == m_div, "R7", "active divider code", div_o, m_div);
        end
    end

    // ---------------- phase-width monitor (R8) ----------------
    bit  mon_on = 1'b0;
    real last_t = 0.0;
    real min_w  = 1000.0;
    always @(sys_clk) begin
        if (mon_on && ($realtime - last_t) < min_w) min_w = $realtime - last_t;
        last_t = $realtime;
    end

    // ---------------- stimulus helpers ----------------
    task automatic cycles(input int n);
        repeat (n) @(negedge osc_clk);
    endtask

    task automatic write_ctrl(input logic [3:0] d);
        @(negedge osc_clk); wr = 1'b1; wd = d;
        @(negedge osc_clk); wr = 1'b0;
    endtask

    task automatic measure(input real exp_p, input string req);
        real t0, t1, t2;
        @(posedge sys_clk); t0 = $realtime;
        @(negedge sys_clk); t1 = $realtime;
        @(posedge sys_clk); t2 = $realtime;
        chk_r(((t2-t0) > exp_p-0.02) && ((t2-t0) < exp_p+0.02), req,
              "sys_clk period ns", t2-t0, exp_p);
        chk_r(((t1-t0) > exp_p/2-0.02) && ((t1-t0) < exp_p/2+0.02), "R4",
              "sys_clk high time ns", t1-t0, exp_p/2);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge osc_clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // ---------------- test sequence ----------------
    initial begin
        cycles(5);
        @(negedge osc_clk); rst_n = 1'b1;
        model_go = 1'b1;
        cycles(10);
        mon_on = 1'b1;
        cycles(20);

        // R1: reset state
        chk(en_o == 0 && lock_o == 0 && conn_o == 0, "R1", "status after reset",
            {en_o, lock_o, conn_o}, 0);
        chk(div_o == 0, "R1", "divider code after reset", div_o, 0);
        chk(osc_on == 1 && pll_on == 0, "R1", "source gates after reset",
            {osc_on, pll_on}, 2);
        measure(OSC_P, "R1");

        // R3: connect without enable is refused
        write_ctrl(4'b0010);
        cycles(3);
        chk(conn_o == 0, "R3", "connect before enable", conn_o, 0);

        // R2: enable; lock input arrives early, flag waits for counter
        write_ctrl(4'b0001);
        cycles(100);
        lock_in = 1'b1;
        cycles(200);
        write_ctrl(4'b0011);               // R3: connect during settle
        cycles(5);
        chk(conn_o == 0, "R3", "connect during settle", conn_o, 0);
        chk(pll_on == 0, "R3", "PLL gate during settle", pll_on, 0);
        cycles(300);
        chk(lock_o == 0, "R2", "lock before settle done", lock_o, 0);
        cycles(700);
        chk(lock_o == 1, "R2", "lock after settle", lock_o, 1);

        // R4/R5: connect with code 0 (ratio 2)
        write_ctrl(4'b0011);
        cycles(60);
        chk(pll_on == 1 && osc_on == 0, "R4", "gates when connected",
            {osc_on, pll_on}, 1);
        measure(VCO_P*2, "R5");

        // R7: code written while connected is held
        write_ctrl(4'b1111);
        cycles(40);
        chk(div_o == 0, "R7", "code held while connected", div_o, 0);
        measure(VCO_P*2, "R7");

        // back to bypass: held code applies; then ratio 16
        write_ctrl(4'b1101);
        cycles(60);
        chk(div_o == 3, "R7", "held code applied in bypass", div_o, 3);
        chk(osc_on == 1 && pll_on == 0, "R8", "gates after disconnect",
            {osc_on, pll_on}, 2);
        measure(OSC_P, "R8");
        write_ctrl(4'b1111);
        cycles(60);
        measure(VCO_P*16, "R5");

        // ratio 4
        write_ctrl(4'b0101);
        cycles(60);
        write_ctrl(4'b0111);
        cycles(60);
        chk(div_o == 1, "R5", "code 1 active", div_o, 1);
        measure(VCO_P*4, "R5");

        // ratio 8
        write_ctrl(4'b1001);
        cycles(60);
        write_ctrl(4'b1011);
        cycles(60);
        measure(VCO_P*8, "R5");

        // R6: disable while connected
        write_ctrl(4'b1000);
        chk(lock_o == 0 && conn_o == 0 && en_o == 0, "R6",
            "status after disable", {en_o, lock_o, conn_o}, 0);
        cycles(60);
        chk(osc_on == 1 && pll_on == 0, "R6", "gates after disable",
            {osc_on, pll_on}, 2);
        measure(OSC_P, "R6");

        // R9: re-enable, relock, connect, then lose lock input
        write_ctrl(4'b0001);
        cycles(S + 20);
        chk(lock_o == 1, "R2", "relock after re-enable", lock_o, 1);
        write_ctrl(4'b0011);
        cycles(60);
        chk(pll_on == 1, "R4", "PLL gate after reconnect", pll_on, 1);
        @(negedge osc_clk); lock_in = 1'b0;
        cycles(2);
        chk(lock_o == 1, "R9", "lock two edges after input drop", lock_o, 1);
        cycles(1);
        chk(lock_o == 0 && conn_o == 0, "R9", "status after lock loss",
            {lock_o, conn_o}, 0);
        cycles(60);
        chk(osc_on == 1 && pll_on == 0, "R9", "gates after lock loss",
            {osc_on, pll_on}, 2);
        measure(OSC_P, "R9");

        // R8: no runt phase anywhere in the run
        chk_r(min_w > 1.2, "R8", "narrowest sys_clk phase ns", min_w, VCO_P);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule